// File: doc/BRIEF.md
# Triggered SAR ADC Readout Controller

This controller services a serial successive-approximation converter wired in three-wire mode, where the converter's serial input is tied high and there is no busy indicator. The convert line does two jobs. Its rising edge starts a conversion, and its falling edge acts as a chip select that puts the most significant bit on the data line. Because the converter gives no completion flag, the controller waits a fixed, parameterised number of system clocks before it reads.

A falling edge on the trigger input starts one cycle. The controller raises the convert line and holds it for `CONV_CYCLES` clocks, then drops it. It then generates `WIDTH` serial clock pulses, each half period `SCK_HALF` clocks long, with no gap between bytes. It samples the data line on every rising serial clock edge, MSB first. The assembled word is presented with a one-cycle valid strobe, and the controller returns to idle. The convert line stays low while idle, which leaves the converter acquiring the next sample. A trigger edge that arrives while a cycle is in flight is dropped and recorded in a sticky overrun flag.

Top module: `sar_trig_reader`

## Requirements
- R1: After reset, the convert output, serial clock, busy, valid and overrun outputs are all low.
- R2: A high-to-low transition of `trig` seen while idle makes the convert output and busy go high on the next clock edge.
- R3: The convert output stays high for exactly `CONV_CYCLES` clock cycles per cycle.
- R4: The converter serial-input drive `sdi_o` is constant high.
- R5: The serial clock idles low and never is high while the convert output is high.
- R6: Each cycle produces exactly `WIDTH` serial clock rising edges, spaced exactly `2*SCK_HALF` clocks apart with no gap.
- R7: The output word is MSB first: bit `WIDTH-1` is the data-line value present after the convert line falls, and each lower bit is the value presented after each successive serial clock falling edge.
- R8: `valid_o` is high for exactly one cycle per completed read, carries the word on `data_o`, and busy is low in that cycle.
- R9: A `trig` falling edge while busy does not start or disturb a cycle and sets `overrun_o`, which then stays high.
- R10: `clr_ovr` clears `overrun_o` on the next edge; if an overrun event happens in the same cycle, the flag stays set.
- R11: Only a high-to-low transition starts a cycle: `trig` held low, or a rising `trig`, starts nothing and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Trigger; a falling edge starts a cycle |
| clr_ovr | input | 1 | Clears the sticky overrun flag |
| sdo_in | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Convert start and chip select to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdi_o | output | 1 | Converter serial input, held high |
| data_o | output | WIDTH | Last completed result |
| valid_o | output | 1 | One-cycle strobe for `data_o` |
| busy_o | output | 1 | High from the accepted trigger until the word is delivered |
| overrun_o | output | 1 | Sticky flag for triggers dropped while busy |

## Verification
The bench keeps the default `CONV_CYCLES` of 450 and `WIDTH` of 16, so a full 4.5 us hold and a real two-byte read are exercised. It sets `SCK_HALF` to 7, which gives a serial clock just over 7 MHz. With these values, a single cycle takes about 700 clocks. That is short enough to run several bit patterns and to place overrun triggers both inside the conversion wait and inside the serial read, and it leaves room for a clear that collides with a dropped trigger.

// File: rtl/sar_trig_reader.sv
`timescale 1ns/1ps
module sar_trig_reader #(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 450,
  parameter int SCK_HALF    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             clr_ovr,
  input  logic             sdo_in,
  output logic             cnv_o,
  output logic             sck_o,
  output logic             sdi_o,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o,
  output logic             busy_o,
  output logic             overrun_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int DW = $clog2(SCK_HALF + 1);
  localparam int BW = $clog2(WIDTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_READ, S_TAIL} st_t;

  st_t              state;
  logic             trig_q;
  logic [CW-1:0]    hold_cnt;
  logic [DW-1:0]    div_cnt;
  logic [BW-1:0]    nbits;
  logic [WIDTH-1:0] shreg;
  logic             trig_fall;
  logic             half_done;

  assign trig_fall = trig_q & ~trig;
  assign half_done = (div_cnt == DW'(SCK_HALF - 1));
  assign cnv_o     = (state == S_CONV);
  assign busy_o    = (state != S_IDLE);
  assign sdi_o     = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      trig_q    <= 1'b1;
      hold_cnt  <= '0;
      div_cnt   <= '0;
      nbits     <= '0;
      shreg     <= '0;
      sck_o     <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      trig_q  <= trig;
      valid_o <= 1'b0;

      if (trig_fall && state != S_IDLE) overrun_o <= 1'b1;
      else if (clr_ovr)                 overrun_o <= 1'b0;

      case (state)
        S_IDLE: begin
          if (trig_fall) begin
            state    <= S_CONV;
            hold_cnt <= '0;
          end
        end
        S_CONV: begin
          if (hold_cnt == CW'(CONV_CYCLES - 1)) begin
            state   <= S_READ;
            div_cnt <= '0;
            nbits   <= '0;
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        S_READ: begin
          if (half_done) begin
            div_cnt <= '0;
            sck_o   <= ~sck_o;
            if (!sck_o) begin
              shreg <= {shreg[WIDTH-2:0], sdo_in};
              nbits <= nbits + 1'b1;
              if (nbits == BW'(WIDTH - 1)) state <= S_TAIL;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: begin
          if (half_done) begin
            div_cnt <= '0;
            sck_o   <= 1'b0;
            data_o  <= shreg;
            valid_o <= 1'b1;
            state   <= S_IDLE;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sar_trig_reader_chk.sv
`timescale 1ns/1ps
module sar_trig_reader_chk #(
  parameter int CONV_CYCLES = 450
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic sck_o,
  input logic sdi_o,
  input logic valid_o,
  input logic busy_o,
  input logic overrun_o,
  input logic clr_ovr
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_cnt <= '0;
    else if (cnv_o) hi_cnt <= hi_cnt + 1;
    else            hi_cnt <= '0;
  end

  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> hi_cnt == 32'(CONV_CYCLES)); // R3
  AST_CONV_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> hi_cnt < 32'(CONV_CYCLES)); // R3
  AST_CNV_RISE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> busy_o); // R2
  AST_SDI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sdi_o); // R4
  AST_SCK_QUIET_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> !sck_o); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R8
  AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !clr_ovr) |=> overrun_o); // R9
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && !busy_o) |=> !overrun_o); // R10
endmodule

bind sar_trig_reader sar_trig_reader_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_o(cnv_o), .sck_o(sck_o), .sdi_o(sdi_o),
  .valid_o(valid_o), .busy_o(busy_o), .overrun_o(overrun_o), .clr_ovr(clr_ovr)
);

// File: tb/tb_sar_trig_reader.sv
`timescale 1ns/1ps
module tb_sar_trig_reader;
  localparam int WIDTH = 16;
  localparam int CONV  = 450;
  localparam int HALF  = 7;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b1, clr_ovr = 1'b0, sdo_in = 1'b0;
  logic cnv_o, sck_o, sdi_o, valid_o, busy_o, overrun_o;
  logic [WIDTH-1:0] data_o;

  always #5 clk = ~clk;

  sar_trig_reader #(.WIDTH(WIDTH), .CONV_CYCLES(CONV), .SCK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .clr_ovr(clr_ovr), .sdo_in(sdo_in),
    .cnv_o(cnv_o), .sck_o(sck_o), .sdi_o(sdi_o), .data_o(data_o),
    .valid_o(valid_o), .busy_o(busy_o), .overrun_o(overrun_o)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // converter model
  logic [WIDTH-1:0] next_word = '0, conv_word = '0;
  int bit_idx = -1;
  always @(posedge cnv_o) conv_word = next_word;
  always @(negedge cnv_o) begin sdo_in = conv_word[WIDTH-1]; bit_idx = WIDTH - 2; end
  always @(negedge sck_o) if (bit_idx >= 0) begin sdo_in = conv_word[bit_idx]; bit_idx--; end

  // scoreboard monitor
  logic [WIDTH-1:0] exp_q[$];
  int cyc = 0, cnv_len = 0, rises = 0, last_rise = -1;
  bit per_bad = 0, sck_in_cnv = 0, sdi_bad = 0;
  logic cnv_p = 1'b0, sck_p = 1'b0, valid_p = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!sdi_o) sdi_bad = 1;
      if (cnv_o) cnv_len++;
      if (cnv_o && sck_o) sck_in_cnv = 1;
      if (!cnv_o && cnv_p) begin
        chk(cnv_len == CONV, "R3", "convert high cycles", cnv_len, CONV);
        cnv_len = 0; rises = 0; per_bad = 0; last_rise = -1;
      end
      if (sck_o && !sck_p) begin
        if (last_rise >= 0 && cyc - last_rise != 2 * HALF) per_bad = 1;
        last_rise = cyc;
        rises++;
      end
      if (valid_o) begin
        chk(rises == WIDTH, "R6", "sck rising edges", rises, WIDTH);
        chk(!per_bad, "R6", "sck period irregular", per_bad, 0);
        chk(!busy_o, "R8", "busy during valid", busy_o, 0);
        chk(!sck_in_cnv && !sck_o, "R5", "sck activity outside read", sck_in_cnv, 0);
        if (exp_q.size() == 0) chk(0, "R9", "unexpected word", data_o, 0);
        else begin
          logic [WIDTH-1:0] e;
          e = exp_q.pop_front();
          chk(data_o == e, "R7", "data word", data_o, e);
        end
      end
      if (valid_o && valid_p) chk(0, "R8", "valid wider than one cycle", 2, 1);
    end
    cnv_p = cnv_o; sck_p = sck_o; valid_p = valid_o;
  end

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b0;
    repeat (3) @(negedge clk);
    trig = 1'b1;
  endtask

  task automatic send(input logic [WIDTH-1:0] w);
    next_word = w;
    exp_q.push_back(w);
    pulse_trig();
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic stay_idle(input string req, input int n);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy_o || cnv_o) bad = 1;
    end
    chk(!bad, req, "cycle started without falling edge", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  logic [WIDTH-1:0] pats [8] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001,
                                 16'hA5A5, 16'h5A5A, 16'h1234, 16'hFE01};

  initial begin
    repeat (4) @(negedge clk);
    chk({cnv_o, sck_o, busy_o, valid_o, overrun_o} == 5'b0, "R1", "reset outputs",
        {cnv_o, sck_o, busy_o, valid_o, overrun_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({cnv_o, sck_o, busy_o, valid_o, overrun_o} == 5'b0, "R1", "idle outputs",
        {cnv_o, sck_o, busy_o, valid_o, overrun_o}, 0);
    chk(sdi_o == 1'b1, "R4", "sdi level", sdi_o, 1);

    // R2: start latency
    next_word = 16'hC3A5; exp_q.push_back(16'hC3A5);
    @(negedge clk) trig = 1'b0;
    chk(!cnv_o, "R2", "convert before edge", cnv_o, 0);
    @(negedge clk);
    chk(cnv_o && busy_o, "R2", "convert/busy after edge", {cnv_o, busy_o}, 3);
    repeat (2) @(negedge clk);
    trig = 1'b1;
    wait_idle();

    // R7 patterns
    for (int i = 0; i < 8; i++) begin
      send(pats[i]);
      wait_idle();
    end
    chk(!overrun_o, "R9", "overrun without dropped trigger", overrun_o, 0);

    // R9 during conversion
    send(16'h6B2D);
    repeat (100) @(negedge clk);
    pulse_trig();
    chk(overrun_o, "R9", "overrun in conversion", overrun_o, 1);
    chk(cnv_o, "R9", "conversion disturbed", cnv_o, 1);
    wait_idle();
    stay_idle("R9", 20);
    chk(overrun_o, "R9", "overrun sticky", overrun_o, 1);

    // R10 clear
    @(negedge clk) clr_ovr = 1'b1;
    @(negedge clk) clr_ovr = 1'b0;
    chk(!overrun_o, "R10", "overrun after clear", overrun_o, 0);

    // R9 during read, then R10 collision
    send(16'h9E47);
    repeat (CONV + 30) @(negedge clk);
    chk(busy_o && !cnv_o, "R9", "in read phase", {busy_o, cnv_o}, 2);
    pulse_trig();
    chk(overrun_o, "R9", "overrun in read", overrun_o, 1);
    @(negedge clk) begin trig = 1'b0; clr_ovr = 1'b1; end
    @(negedge clk) begin trig = 1'b1; clr_ovr = 1'b0; end
    chk(overrun_o, "R10", "set wins over clear", overrun_o, 1);
    wait_idle();
    @(negedge clk) clr_ovr = 1'b1;
    @(negedge clk) clr_ovr = 1'b0;
    chk(!overrun_o, "R10", "cleared when idle", overrun_o, 0);

    // R11 level held low, then rising edge
    next_word = 16'h3C96; exp_q.push_back(16'h3C96);
    @(negedge clk) trig = 1'b0;
    wait_idle();
    stay_idle("R11", 40);
    @(negedge clk) trig = 1'b1;
    stay_idle("R11", 20);
    chk(!overrun_o, "R11", "overrun from held level", overrun_o, 0);

    chk(exp_q.size() == 0, "R8", "words left undelivered", exp_q.size(), 0);
    chk(!sdi_bad, "R4", "sdi dropped low", sdi_bad, 0);
    summary();
    $finish;
  end
endmodule